// File: doc/BRIEF.md
# Synchronization Clock Divider with Phase Slip

This block divides the system clock by four to make a synchronization clock for external parallel logic. The clock comes out in two forms. The internal phase never stops. The pin copy can be held at logic 0 to cut switching noise, and the internal timing keeps running while it is held.

An external sync-in pin lets board logic line up several devices. While the manual sync enable is set, each rising edge seen on that pin makes the divider skip one count. This moves every later sync clock edge one system clock cycle earlier. The enable is a plain level that software owns. The block never clears it. A high-speed sync enable bit is also stored and reported back.

Top module: `syncclk_div`

## Requirements
- R1: While rst_n is low, the divider count is 0, and sync_clk_int, sync_clk_pin and hs_sync_flag are all 0.
- R2: With no slip, the count advances by one on each clock. sync_clk_int is 1 when the 2-bit count is 2 or 3 and 0 when it is 0 or 1, which gives a period of four clocks.
- R3: sync_in passes through a two-stage synchronizer. When manual_sync_en is 1 and a 0-to-1 change of sync_in is detected, the count advances by two on the third rising clock edge after sync_in goes high. The period that contains the slip is three clocks long.
- R4: If sync_in stays high, it causes exactly one slip. Another slip needs sync_in to go low and then high again.
- R5: When manual_sync_en is 0, changes on sync_in have no effect on the count, on sync_clk_int or on sync_clk_pin.
- R6: When pin_disable is 1, sync_clk_pin is 0 and sync_clk_int keeps toggling as in R2. When pin_disable is 0, sync_clk_pin equals sync_clk_int.
- R7: hs_sync_flag shows the value that hs_sync_en had at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | External manual sync pin, asynchronous |
| manual_sync_en | input | 1 | Lets sync_in edges cause a slip |
| pin_disable | input | 1 | Holds the pin copy of the sync clock at 0 |
| hs_sync_en | input | 1 | High-speed sync enable, stored only |
| sync_clk_pin | output | 1 | Sync clock as driven to the pin |
| sync_clk_int | output | 1 | Internal sync clock phase, always running |
| hs_sync_flag | output | 1 | Stored high-speed sync enable |

## Verification
The assertions check the count on every cycle. Without a slip the count steps by one. With a slip it steps by two. A slip never lasts more than one cycle, and a cleared enable always gives a single step. The other behaviours need the bench's reference model, which is fed sync_in stimulus cycle by cycle:
- the exact three-cycle latency from the pin to the slip;
- the single slip for a held-high pin;
- slips at each of the four count phases;
- the gating of the pin copy while the internal phase runs on.

// File: rtl/syncclk_div.sv
module syncclk_div #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic manual_sync_en,
  input  logic pin_disable,
  input  logic hs_sync_en,
  output logic sync_clk_pin,
  output logic sync_clk_int,
  output logic hs_sync_flag
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0]  sy;
  logic [CNT_W-1:0] cnt;
  logic             rise, slip;

  assign rise = sy[SYNC_STAGES-1] & ~sy[SYNC_STAGES];
  assign slip = rise & manual_sync_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy           <= '0;
      cnt          <= '0;
      hs_sync_flag <= 1'b0;
    end else begin
      sy           <= {sy[SH_W-2:0], sync_in};
      cnt          <= cnt + (slip ? CNT_W'(2) : CNT_W'(1));
      hs_sync_flag <= hs_sync_en;
    end
  end

  assign sync_clk_int = cnt[CNT_W-1];
  assign sync_clk_pin = sync_clk_int & ~pin_disable;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !slip |=> cnt == $past(cnt) + CNT_W'(1));

  p_slip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> cnt == $past(cnt) + CNT_W'(2));

  p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> !slip);

  p_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !manual_sync_en |=> cnt == $past(cnt) + CNT_W'(1));
endmodule

// File: tb/syncclk_div_tb.sv
module syncclk_div_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  pin;
    logic  intc;
    logic  hs;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_in = 1'b0, manual_sync_en = 1'b0, pin_disable = 1'b0, hs_sync_en = 1'b0;
  logic sync_clk_pin, sync_clk_int, hs_sync_flag;

  int   tests = 0, fails = 0;
  exp_t q[$];
  logic m1 = 0, m2 = 0, m3 = 0;
  logic [1:0] mcnt = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  syncclk_div dut_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .manual_sync_en(manual_sync_en),
    .pin_disable(pin_disable), .hs_sync_en(hs_sync_en),
    .sync_clk_pin(sync_clk_pin), .sync_clk_int(sync_clk_int), .hs_sync_flag(hs_sync_flag)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic en, input logic dis, input logic hs, input string tag);
    exp_t e;
    logic slip;
    @(negedge clk);
    rst_n = 1'b1;
    sync_in = s; manual_sync_en = en; pin_disable = dis; hs_sync_en = hs;
    slip = m2 & ~m3 & en;
    m3 = m2; m2 = m1; m1 = s;
    mcnt = mcnt + (slip ? 2'd2 : 2'd1);
    e.intc = mcnt[1];
    e.pin  = mcnt[1] & ~dis;
    e.hs   = hs;
    e.tag  = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " int"}, sync_clk_int, e.intc);
      chk({e.tag, " pin"}, sync_clk_pin, e.pin);
      chk({e.tag, " hs R7"}, hs_sync_flag, e.hs);
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 int", sync_clk_int, 1'b0);
    chk("R1 pin", sync_clk_pin, 1'b0);
    chk("R1 hs", hs_sync_flag, 1'b0);
    hs_sync_en = 1'b1; sync_in = 1'b1; manual_sync_en = 1'b1;
    @(negedge clk);
    chk("R1 hs held in reset", hs_sync_flag, 1'b0);
    chk("R1 int held in reset", sync_clk_int, 1'b0);
    sync_in = 1'b0; manual_sync_en = 1'b0; hs_sync_en = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 12; i++) step(0, 0, 0, 0, "R2 free run");
    for (int i = 0; i < 6; i++) step(0, 0, 0, i[0], "R7 hs toggle");

    step(1, 1, 0, 0, "R3 slip");
    step(1, 1, 0, 0, "R3 slip");
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0, "R3 slip");

    for (int ph = 0; ph < 4; ph++) begin
      for (int k = 0; k <= ph; k++) step(0, 1, 0, 0, "R3 phase");
      step(1, 1, 0, 0, "R3 phase");
      for (int k = 0; k < 7; k++) step(0, 1, 0, 0, "R3 phase");
    end

    for (int i = 0; i < 14; i++) step(1, 1, 0, 0, "R4 held high");
    step(0, 1, 0, 0, "R4 release");
    step(1, 1, 0, 0, "R4 second edge");
    for (int i = 0; i < 6; i++) step(0, 1, 0, 0, "R4 second edge");

    for (int i = 0; i < 16; i++) step(i[1], 0, 0, 0, "R5 ignored");

    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, "R6 pin off");
    step(1, 1, 1, 0, "R6 pin off slip");
    for (int i = 0; i < 6; i++) step(0, 1, 1, 0, "R6 pin off slip");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, "R6 pin on");

    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule